// File: doc/BRIEF.md
# SPI NAND Command Frame Engine

This block is a single-lane SPI master that runs one complete flash command frame on request. It frames the transfer with chip select held low throughout, and sends the phases in a fixed order: a single opcode byte, then 0 to 3 address bytes, then 0 to 3 dummy bytes, then one data phase. The data phase either transmits bytes taken from a byte stream or receives bytes onto a byte stream. Any phase with a zero count is left out entirely.

The requester sets the frame fields and the SCLK divider and pulses `start` while the engine is idle. The fields are latched at that point. Typical frames are an identification read (opcode 0x9F and three received bytes, of which the second and third form the ID), a register read (opcode 0x0F, one address byte naming the register, e.g. 0xC0 for status, then one received byte) and a register write (opcode 0x1F, one address byte, then one transmitted byte). Both byte streams use valid/ready flow control. SCLK simply pauses while a stream stalls.

Top module: `spi_frame_engine`

## Requirements
- R1: After an accepted `start`, the first byte on `mosi` is `opcode`, sent exactly once, and `cs_n` stays low from the first SCLK edge of the frame to the last.
- R2: The address phase sends the low `addr_cnt` bytes of `addr`, most significant first (count 3 sends bits 23:16, then 15:8, then 7:0; count 1 sends bits 7:0). With `addr_cnt` = 0 no address byte is sent.
- R3: The dummy phase sends `dummy_cnt` bytes of value 0xFF, and nothing when `dummy_cnt` = 0.
- R4: The data phase comes last. It carries `data_len` bytes, transmitted when `rx_mode` = 0 and received when `rx_mode` = 1. It is skipped when `data_len` = 0. While receiving, `mosi` carries 0xFF.
- R5: SPI mode 0 is used. SCLK is low when idle and data is MSB first. `mosi` changes only while SCLK is low, and `miso` is sampled on the rising edge. Each SCLK high time lasts exactly `div`+1 system clocks.
- R6: A transmit byte is consumed on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` is high only while the engine waits for the next transmit byte. While it waits, SCLK stays low and `cs_n` stays low.
- R7: Each received byte appears on `rx_data` with `rx_valid` high. It is held stable until `rx_ready` is high, and the next byte is not clocked in while one is still pending.
- R8: `busy` rises in the cycle after an accepted `start` and stays high until `done`. `done` is a one-cycle pulse with `busy` low. A `start` while busy is ignored.
- R9: After the last byte, `cs_n` is high for at least two SCLK periods (4·(`div`+1) system clocks) before `done`. After reset, `cs_n` is high and SCLK is low.
- R10: Data phases of up to 2^LEN_W−1 bytes are supported, and 2112 bytes with the default LEN_W = 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request, taken while idle |
| opcode | input | 8 | Command byte |
| addr_cnt | input | 2 | Number of address bytes, 0 to 3 |
| addr | input | 24 | Address, sent from its low `addr_cnt` bytes |
| dummy_cnt | input | DUMMY_W | Number of 0xFF dummy bytes |
| rx_mode | input | 1 | 1 = receive data phase, 0 = transmit |
| data_len | input | LEN_W | Data phase length in bytes |
| div | input | DIV_W | SCLK half period in system clocks, minus one |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine takes a transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Consumer takes the received byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench aims at the phase-skipping corners. These are an opcode-only frame, a frame with address but no dummy, and a frame with every phase populated. A design that mis-sequences these would send a stray or missing byte, and the byte-exact MOSI comparison catches that. Both streams are stalled irregularly so that a design which clocks bytes in while one is pending, or clocks on while no transmit byte is present, shows up as lost or repeated data. A start pulsed mid-frame checks that a second frame is not launched. A 2112-byte transmit at the fastest divider exercises the length counter at its practical limit, and per-clock monitors time the SCLK high phases and the chip-select gap.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_MAX = 3;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_PICK,
    S_DATA,
    S_XFER,
    S_GAP
  } seq_state_t;
endpackage

// File: rtl/spif_tick.sv
module spif_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign tick = en && (cnt_q == div);
endmodule

// File: rtl/spif_shift.sv
module spif_shift
  import spif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              active,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] out_q;
  logic [BYTE_W-1:0] in_q;
  logic [BIT_W-1:0]  bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= '0;
      in_q      <= '0;
      bit_q     <= '0;
      sclk      <= 1'b0;
      active    <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        out_q  <= byte_in;
        bit_q  <= '0;
        sclk   <= 1'b0;
        active <= 1'b1;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          in_q <= {in_q[BYTE_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_q == BIT_W'(BYTE_W - 1)) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
            rx_byte   <= in_q;
          end else begin
            out_q <= {out_q[BYTE_W-2:0], 1'b0};
            bit_q <= bit_q + BIT_W'(1);
          end
        end
      end
    end
  end

  assign mosi = out_q[BYTE_W-1];
endmodule

// File: rtl/spif_seq.sv
module spif_seq
  import spif_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int DIV_W    = 8,
  parameter int DUMMY_W  = 2,
  parameter int GAP_SCLK = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [BYTE_W-1:0]           opcode,
  input  logic [1:0]                  addr_cnt,
  input  logic [ADDR_MAX*BYTE_W-1:0]  addr,
  input  logic [DUMMY_W-1:0]          dummy_cnt,
  input  logic                        rx_mode,
  input  logic [LEN_W-1:0]            data_len,
  input  logic [DIV_W-1:0]            div,
  input  logic                        tick,
  input  logic                        sh_done,
  input  logic [BYTE_W-1:0]           sh_rx,
  input  logic [BYTE_W-1:0]           tx_data,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  output logic [BYTE_W-1:0]           rx_data,
  output logic                        rx_valid,
  input  logic                        rx_ready,
  output logic                        ld,
  output logic [BYTE_W-1:0]           ld_byte,
  output logic [DIV_W-1:0]            div_q,
  output logic                        gap_en,
  output logic                        cs_n,
  output logic                        busy,
  output logic                        done
);
  localparam int AW        = ADDR_MAX * BYTE_W;
  localparam int GAP_TICKS = 2 * GAP_SCLK;
  localparam int GW        = $clog2(GAP_TICKS + 1);

  seq_state_t           state_q;
  logic [1:0]           acnt_q;
  logic [AW-1:0]        abuf_q;
  logic [DUMMY_W-1:0]   dcnt_q;
  logic                 dir_q;
  logic [LEN_W-1:0]     left_q;
  logic [GW-1:0]        gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      acnt_q   <= '0;
      abuf_q   <= '0;
      dcnt_q   <= '0;
      dir_q    <= 1'b0;
      left_q   <= '0;
      gap_q    <= '0;
      div_q    <= '0;
      ld       <= 1'b0;
      ld_byte  <= '0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      done <= 1'b0;
      ld   <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            abuf_q  <= addr << (5'd24 - {addr_cnt, 3'b000});
            acnt_q  <= addr_cnt;
            dcnt_q  <= dummy_cnt;
            dir_q   <= rx_mode;
            left_q  <= data_len;
            div_q   <= div;
            cs_n    <= 1'b0;
            busy    <= 1'b1;
            ld      <= 1'b1;
            ld_byte <= opcode;
            state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (sh_done) state_q <= S_PICK;
        end
        S_PICK: begin
          if (acnt_q != 2'd0) begin
            ld      <= 1'b1;
            ld_byte <= abuf_q[AW-1 -: BYTE_W];
            abuf_q  <= abuf_q << BYTE_W;
            acnt_q  <= acnt_q - 2'd1;
            state_q <= S_WAIT;
          end else if (dcnt_q != '0) begin
            ld      <= 1'b1;
            ld_byte <= FILL_BYTE;
            dcnt_q  <= dcnt_q - DUMMY_W'(1);
            state_q <= S_WAIT;
          end else if (left_q != '0) begin
            state_q <= S_DATA;
          end else begin
            cs_n    <= 1'b1;
            gap_q   <= '0;
            state_q <= S_GAP;
          end
        end
        S_DATA: begin
          if (dir_q) begin
            if (!rx_valid) begin
              ld      <= 1'b1;
              ld_byte <= FILL_BYTE;
              state_q <= S_XFER;
            end
          end else if (tx_valid) begin
            ld      <= 1'b1;
            ld_byte <= tx_data;
            state_q <= S_XFER;
          end
        end
        S_XFER: begin
          if (sh_done) begin
            left_q <= left_q - LEN_W'(1);
            if (dir_q) begin
              rx_valid <= 1'b1;
              rx_data  <= sh_rx;
            end
            state_q <= S_PICK;
          end
        end
        S_GAP: begin
          if (tick) begin
            if (gap_q == GW'(GAP_TICKS - 1)) begin
              done    <= 1'b1;
              busy    <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              gap_q <= gap_q + GW'(1);
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tx_ready = (state_q == S_DATA) && !dir_q;
  assign gap_en   = (state_q == S_GAP);
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spif_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int DIV_W    = 8,
  parameter int DUMMY_W  = 2,
  parameter int GAP_SCLK = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [7:0]         opcode,
  input  logic [1:0]         addr_cnt,
  input  logic [23:0]        addr,
  input  logic [DUMMY_W-1:0] dummy_cnt,
  input  logic               rx_mode,
  input  logic [LEN_W-1:0]   data_len,
  input  logic [DIV_W-1:0]   div,
  input  logic [7:0]         tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic               busy,
  output logic               done,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  logic              tick;
  logic              sh_active;
  logic              sh_done;
  logic [BYTE_W-1:0] sh_rx;
  logic              ld;
  logic [BYTE_W-1:0] ld_byte;
  logic [DIV_W-1:0]  div_q;
  logic              gap_en;

  spif_tick #(.DIV_W(DIV_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (sh_active | gap_en),
    .div (div_q),
    .tick(tick)
  );

  spif_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .byte_in  (ld_byte),
    .tick     (tick),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .active   (sh_active),
    .byte_done(sh_done),
    .rx_byte  (sh_rx)
  );

  spif_seq #(
    .LEN_W   (LEN_W),
    .DIV_W   (DIV_W),
    .DUMMY_W (DUMMY_W),
    .GAP_SCLK(GAP_SCLK)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .opcode   (opcode),
    .addr_cnt (addr_cnt),
    .addr     (addr),
    .dummy_cnt(dummy_cnt),
    .rx_mode  (rx_mode),
    .data_len (data_len),
    .div      (div),
    .tick     (tick),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .ld       (ld),
    .ld_byte  (ld_byte),
    .div_q    (div_q),
    .gap_en   (gap_en),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done)
  );
endmodule

// File: rtl/spif_checker.sv
module spif_checker (
  input logic       clk,
  input logic       rst,
  input logic       sclk,
  input logic       cs_n,
  input logic       mosi,
  input logic       busy,
  input logic       done,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  // R5, R9: SCLK rests low whenever chip select is released
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R5: MOSI holds while SCLK stays high
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R1: chip select low only inside a busy frame
  p_cs_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R8: done is a single-cycle pulse with busy already low
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: transmit bytes are requested only inside a frame with CS low
  p_tx_ready_r6: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (busy && !cs_n));

  // R7: a pending received byte is held until taken
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_frame_engine spif_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .sclk    (sclk),
  .cs_n    (cs_n),
  .mosi    (mosi),
  .busy    (busy),
  .done    (done),
  .tx_ready(tx_ready),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .rx_data (rx_data)
);

// File: tb/spi_frame_engine_tb.sv
module spi_frame_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [1:0]  addr_cnt = '0;
  logic [23:0] addr = '0;
  logic [1:0]  dummy_cnt = '0;
  logic        rx_mode = 1'b0;
  logic [11:0] data_len = '0;
  logic [7:0]  div = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        busy, done, sclk, cs_n, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int mon_err = 0;
  int done_cnt = 0;
  int cur_div = 0;
  logic [7:0] seed = 8'h00;

  always #4 clk = ~clk;

  spi_frame_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .addr_cnt(addr_cnt), .addr(addr), .dummy_cnt(dummy_cnt),
    .rx_mode(rx_mode), .data_len(data_len), .div(div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] resp(int i);
    return 8'(seed + 8'(i) * 8'd29);
  endfunction

  function automatic logic [7:0] txb(logic [7:0] sd, int k);
    return 8'(sd ^ 8'(k * 13));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Serial slave: records MOSI bytes, drives MISO from resp()
  logic [7:0] got_q[$];
  logic [7:0] shin;
  int         sb;

  always @(negedge cs_n) begin
    sb = 0;
    miso = resp(0)[7];
  end
  always @(posedge sclk) if (!cs_n) begin
    shin = {shin[6:0], mosi};
    sb++;
    if (sb % 8 == 0) got_q.push_back(shin);
  end
  always @(negedge sclk) if (!cs_n) begin
    logic [7:0] v;
    v = resp(sb / 8);
    miso = v[7 - (sb % 8)];
  end

  // Per-clock reference checks on the serial timing
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;
  int   hi_cnt = 0, gap_cnt = 0;
  always @(negedge clk) if (!rst) begin
    if (done) done_cnt++;
    if (cs_n && sclk) begin
      mon_err++; errors++;
      $display("FAIL R5 sclk high with cs_n high: actual 1 expected 0");
    end
    if (sclk && prev_sclk && mosi !== prev_mosi) begin
      mon_err++; errors++;
      $display("FAIL R5 mosi moved while sclk high: actual %0b expected %0b", mosi, prev_mosi);
    end
    if (sclk) hi_cnt++;
    else if (prev_sclk) begin
      if (hi_cnt != cur_div + 1) begin
        mon_err++; errors++;
        $display("FAIL R5 sclk high time: actual %0d expected %0d", hi_cnt, cur_div + 1);
      end
      hi_cnt = 0;
    end
    if (!cs_n) gap_cnt = 0; else gap_cnt++;
    if (done && gap_cnt < 4 * (cur_div + 1)) begin
      mon_err++; errors++;
      $display("FAIL R9 cs_n gap: actual %0d expected >= %0d", gap_cnt, 4 * (cur_div + 1));
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic run_frame(input logic [7:0] op, input int ac, input logic [23:0] ad,
                           input int dc, input bit rxm, input int len, input int dv,
                           input logic [7:0] sd, input int txmod, input int rxmod,
                           input string tag, input bit poke);
    logic [7:0] exp_q[$];
    logic [7:0] rxg_q[$];
    int k, cyc, d0, m0;
    bit pend, ok;
    exp_q.push_back(op);
    for (int i = ac - 1; i >= 0; i--) exp_q.push_back(ad[8*i +: 8]);
    for (int i = 0; i < dc; i++) exp_q.push_back(8'hFF);
    for (int i = 0; i < len; i++) exp_q.push_back(rxm ? 8'hFF : txb(sd, i));
    seed = sd;
    cur_div = dv;
    got_q.delete();
    d0 = done_cnt;
    m0 = mon_err;
    @(negedge clk);
    opcode = op; addr_cnt = 2'(ac); addr = ad; dummy_cnt = 2'(dc);
    rx_mode = rxm; data_len = 12'(len); div = 8'(dv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8", {tag, " busy after start"}, busy, 1);
    k = 0; cyc = 0; pend = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) k++;
      start = (poke && cyc == 20);
      if (poke && cyc == 20) opcode = 8'h55;
      tx_valid = (!rxm && k < len && (cyc % txmod) == 0);
      tx_data = txb(sd, k);
      pend = tx_valid && tx_ready;
      rx_ready = ((cyc % rxmod) == 0);
      if (rx_valid && rx_ready) rxg_q.push_back(rx_data);
      if (done) begin
        chk(busy === 1'b0, "R8", {tag, " busy at done"}, busy, 0);
        break;
      end
    end
    tx_valid = 1'b0;
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rx_ready = 1'b1;
      if (rx_valid) rxg_q.push_back(rx_data);
    end
    rx_ready = 1'b0;
    // R1-R4 byte-exact frame on MOSI
    ok = (got_q.size() == exp_q.size());
    for (int i = 0; ok && i < exp_q.size(); i++) if (got_q[i] !== exp_q[i]) begin
      ok = 0;
      $display("FAIL R1-R4 %s mosi byte %0d: actual %0h expected %0h", tag, i, got_q[i], exp_q[i]);
    end
    chk(ok, "R1/R2/R3/R4", {tag, " mosi byte count"}, got_q.size(), exp_q.size());
    if (rxm) begin
      ok = (rxg_q.size() == len);
      for (int i = 0; ok && i < len; i++)
        if (rxg_q[i] !== resp(1 + ac + dc + i)) ok = 0;
      chk(ok, "R7", {tag, " received stream"}, rxg_q.size(), len);
    end else begin
      chk(rxg_q.size() == 0, "R4", {tag, " no rx bytes in tx frame"}, rxg_q.size(), 0);
    end
    chk(done_cnt - d0 == 1, "R8", {tag, " single done"}, done_cnt - d0, 1);
    chk(cs_n === 1'b1 && busy === 1'b0, "R9", {tag, " idle after frame"}, cs_n, 1);
    chk(mon_err == m0, "R5/R9", {tag, " serial timing"}, mon_err - m0, 0);
    if (rxm && op == 8'h9F && rxg_q.size() == 3)
      chk(rxg_q[1] === resp(2) && rxg_q[2] === resp(3), "R4", "id bytes",
          {rxg_q[1], rxg_q[2]}, {resp(2), resp(3)});
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R9", "reset cs_n/sclk", {cs_n, sclk}, 2);
    chk(busy === 1'b0 && done === 1'b0, "R8", "reset busy/done", {busy, done}, 0);
    chk(tx_ready === 1'b0 && rx_valid === 1'b0, "R6", "reset streams", {tx_ready, rx_valid}, 0);

    run_frame(8'h9F, 0, 24'h0, 0, 1, 3, 1, 8'h21, 1, 1, "id read", 0);
    run_frame(8'h0F, 1, 24'h0000C0, 0, 1, 1, 2, 8'h5A, 1, 5, "reg read", 0);
    run_frame(8'h1F, 1, 24'h0000B0, 0, 0, 1, 1, 8'h10, 1, 1, "reg write", 0);
    run_frame(8'h06, 0, 24'h0, 0, 0, 0, 0, 8'h00, 1, 1, "opcode only", 0);
    run_frame(8'h03, 3, 24'h12A5C3, 1, 1, 5, 1, 8'h77, 1, 3, "r2_r3 full rx", 0);
    run_frame(8'h84, 2, 24'hFF0812, 2, 0, 4, 3, 8'hC4, 4, 1, "r6 stalled tx", 0);
    run_frame(8'h13, 3, 24'h00ABCD, 0, 0, 0, 1, 8'h00, 1, 1, "r8 start ignored", 1);
    run_frame(8'h02, 2, 24'h000000, 0, 0, 2112, 0, 8'h3C, 1, 1, "r10 long tx", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule